// File: doc/BRIEF.md
# Communication Cycle Segment Scheduler

This block divides network time into repeating communication cycles and tells the local node where it stands in each one. A cycle is made of four segments that always come in the same order. A static segment gives each slot to one owner node. A dynamic segment of minislots follows it. Within the dynamic segment a node gets its transmit opportunity in the minislot whose number equals its identifier, so lower identifiers are offered time first. A symbol window comes next, and a network idle gap closes the cycle. Time advances only on `tick`, a one-cycle enable that marks one network time unit (NTU). Each cycle the block counts up a cycle number that wraps modulo 64.

Configuration inputs (`cfg_*`) set the slot counts, the segment lengths, the local node identifier and the static ownership table. These inputs must stay constant while `rst_n` is high and may change only during reset. A dynamic frame request is a valid/ready handshake. The node raises `dyn_valid` with `dyn_len` (frame length in NTUs) and holds both steady until `dyn_ready` is seen high at a tick. `dyn_ready` can rise only at the first NTU of the node's own minislot, and only if the frame fits in what is left of the dynamic segment. If the opportunity passes without a handshake, the request just waits for the next cycle. A request that is withdrawn before the handshake has no effect.

Top module: `cycle_sched`

## Requirements
- R1: In reset and on leaving it, `seg` = 0 (static), `slot_num` = 0, `minislot_num` = 0, `cycle_num` = 0, and `dyn_ready` = `dyn_tx` = 0.
- R2: `seg` encodes static = 0, dynamic = 1, symbol = 2, idle = 3, and moves only as 0→1→2→3→0. The static segment holds `cfg_static_slots` slots of `cfg_slot_len` NTUs each. `slot_num` counts those slots from 0 and is 0 outside the static segment.
- R3: The dynamic segment always lasts `cfg_minislots`×`cfg_minislot_len` NTUs. With no frame granted, `minislot_num` starts at 0 and advances every `cfg_minislot_len` NTUs. It is 0 outside the dynamic segment. The symbol window lasts `cfg_symbol_len` NTUs and the idle gap lasts `cfg_idle_len` NTUs.
- R4: `own_static` is 1 exactly during static slot k when owner field k of `cfg_owner_table` (bits 6k+5 down to 6k) equals `cfg_node_id`.
- R5: `cycle_num` increments when the idle gap ends, at the same tick that `seg` returns to 0, and wraps from 63 to 0.
- R6: While `tick` is 0, no output changes.
- R7: `dyn_ready` = 1 only when all of the following hold: `tick`=1, `dyn_valid`=1, the block is in the first NTU of minislot number `cfg_node_id`, and no frame is in progress.
- R8: A granted frame drives `dyn_tx` = 1 for exactly `dyn_len` NTUs, starting with the granting NTU. During the frame `minislot_num` holds its value. After the frame the next minislot begins at offset 0.
- R9: No grant is given if `dyn_len` is 0 or is larger than the NTUs left in the dynamic segment (counting the current one). A frame that exactly fills the remainder is granted. When no grant is given, minislots keep counting as usual.
- R10: A node whose identifier is never reached as a minislot number within the dynamic segment gets no dynamic opportunity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One network time unit elapses |
| cfg_static_slots | input | SL_W | Number of static slots (1..MAX_STATIC) |
| cfg_slot_len | input | LEN_W | NTUs per static slot (>=1) |
| cfg_minislots | input | MS_W | Number of minislots (>=1) |
| cfg_minislot_len | input | LEN_W | NTUs per minislot (>=1) |
| cfg_symbol_len | input | LEN_W | NTUs in symbol window (>=1) |
| cfg_idle_len | input | LEN_W | NTUs in idle gap (>=1) |
| cfg_node_id | input | 6 | Local node identifier |
| cfg_owner_table | input | MAX_STATIC*6 | Owner ID per static slot, slot k at bits 6k+5:6k |
| dyn_valid | input | 1 | Dynamic frame pending |
| dyn_len | input | DUR_W | Pending frame length in NTUs |
| dyn_ready | output | 1 | Frame accepted on this tick |
| seg | output | 2 | Current segment |
| slot_num | output | SL_W | Current static slot |
| minislot_num | output | MS_W | Current minislot |
| cycle_num | output | 6 | Cycle counter modulo 64 |
| own_static | output | 1 | Local node owns current static slot |
| dyn_tx | output | 1 | Local dynamic frame occupies this NTU |

## Verification
The properties assume that the `cfg_*` inputs are constant outside reset and that all lengths and counts are at least one. They also assume `cfg_static_slots` does not exceed the table size and that `dyn_len` stays constant while `dyn_valid` waits for `dyn_ready`. The bench sets each configuration only while `rst_n` is low. It raises a request before the node's minislot, changes it only at negative edges, and drops it on the NTU after the handshake. It pauses `tick` only between whole NTUs.

// File: rtl/cycle_sched_pkg.sv
package cycle_sched_pkg;
  typedef enum logic [1:0] {
    SEG_STATIC  = 2'd0,
    SEG_DYNAMIC = 2'd1,
    SEG_SYMBOL  = 2'd2,
    SEG_IDLE    = 2'd3
  } seg_e;

  localparam int NODE_W = 6;
  localparam int CYC_W  = 6;
endpackage

// File: rtl/cs_static_slots.sv
module cs_static_slots #(
  parameter int LEN_W = 8,
  parameter int SL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [LEN_W-1:0] slot_len,
  input  logic [SL_W-1:0]  slot_count,
  output logic [SL_W-1:0]  slot_idx,
  output logic             done
);
  logic [LEN_W-1:0] ntu;
  logic             slot_end;

  assign slot_end = (ntu == slot_len - LEN_W'(1));
  assign done     = active && tick && slot_end && (slot_idx == slot_count - SL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntu      <= '0;
      slot_idx <= '0;
    end else if (!active || done) begin
      ntu      <= '0;
      slot_idx <= '0;
    end else if (tick) begin
      if (slot_end) begin
        ntu      <= '0;
        slot_idx <= slot_idx + SL_W'(1);
      end else begin
        ntu <= ntu + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/cs_owner_lookup.sv
module cs_owner_lookup #(
  parameter int MAX_SLOTS = 8,
  parameter int SL_W      = 4,
  parameter int NODE_W    = 6
) (
  input  logic [MAX_SLOTS*NODE_W-1:0] owner_table,
  input  logic [SL_W-1:0]             slot_idx,
  input  logic [NODE_W-1:0]           node_id,
  output logic                        match
);
  logic [MAX_SLOTS-1:0] hit;

  for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
    assign hit[g] = (slot_idx == SL_W'(g)) &&
                    (owner_table[g*NODE_W +: NODE_W] == node_id);
  end

  assign match = |hit;
endmodule

// File: rtl/cs_dynamic.sv
module cs_dynamic #(
  parameter int MS_W   = 8,
  parameter int LEN_W  = 8,
  parameter int NODE_W = 6,
  parameter int DUR_W  = MS_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic [LEN_W-1:0]  ms_len,
  input  logic [MS_W-1:0]   ms_count,
  input  logic [NODE_W-1:0] node_id,
  input  logic              req_valid,
  input  logic [DUR_W-1:0]  req_len,
  output logic              req_ready,
  output logic              tx_active,
  output logic [MS_W-1:0]   ms_idx,
  output logic              done
);
  logic [LEN_W-1:0] ntu;
  logic [DUR_W-1:0] used;
  logic [DUR_W-1:0] left;
  logic [DUR_W-1:0] seg_ticks;
  logic [DUR_W-1:0] remaining;
  logic             busy, opp, fits, grant_now;

  assign seg_ticks = DUR_W'(ms_count) * DUR_W'(ms_len);
  assign remaining = seg_ticks - used;
  assign busy      = (left != '0);
  assign opp       = active && !busy && (ntu == '0) &&
                     (DUR_W'(ms_idx) == DUR_W'(node_id));
  assign fits      = (req_len != '0) && (req_len <= remaining);
  assign grant_now = opp && req_valid && fits;
  assign req_ready = grant_now && tick;
  assign tx_active = busy || grant_now;
  assign done      = active && tick && (used == seg_ticks - DUR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntu    <= '0;
      used   <= '0;
      left   <= '0;
      ms_idx <= '0;
    end else if (!active || done) begin
      ntu    <= '0;
      used   <= '0;
      left   <= '0;
      ms_idx <= '0;
    end else if (tick) begin
      used <= used + DUR_W'(1);
      if (req_ready) begin
        left <= req_len - DUR_W'(1);
        if (req_len == DUR_W'(1)) begin
          ms_idx <= ms_idx + MS_W'(1);
        end
      end else if (busy) begin
        left <= left - DUR_W'(1);
        if (left == DUR_W'(1)) begin
          ms_idx <= ms_idx + MS_W'(1);
          ntu    <= '0;
        end
      end else if (ntu == ms_len - LEN_W'(1)) begin
        ntu    <= '0;
        ms_idx <= ms_idx + MS_W'(1);
      end else begin
        ntu <= ntu + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/cycle_sched.sv
module cycle_sched
  import cycle_sched_pkg::*;
#(
  parameter int MAX_STATIC = 8,
  parameter int LEN_W      = 8,
  parameter int MS_W       = 8,
  localparam int SL_W      = $clog2(MAX_STATIC + 1),
  localparam int DUR_W     = MS_W + LEN_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [SL_W-1:0]              cfg_static_slots,
  input  logic [LEN_W-1:0]             cfg_slot_len,
  input  logic [MS_W-1:0]              cfg_minislots,
  input  logic [LEN_W-1:0]             cfg_minislot_len,
  input  logic [LEN_W-1:0]             cfg_symbol_len,
  input  logic [LEN_W-1:0]             cfg_idle_len,
  input  logic [NODE_W-1:0]            cfg_node_id,
  input  logic [MAX_STATIC*NODE_W-1:0] cfg_owner_table,
  input  logic                         dyn_valid,
  input  logic [DUR_W-1:0]             dyn_len,
  output logic                         dyn_ready,
  output logic [1:0]                   seg,
  output logic [SL_W-1:0]              slot_num,
  output logic [MS_W-1:0]              minislot_num,
  output logic [CYC_W-1:0]             cycle_num,
  output logic                         own_static,
  output logic                         dyn_tx
);
  seg_e             seg_q;
  logic [LEN_W-1:0] tail_cnt;
  logic [CYC_W-1:0] cyc_q;
  logic             static_done, dyn_done, owner_hit;
  logic             in_static, in_dyn;

  assign in_static = (seg_q == SEG_STATIC);
  assign in_dyn    = (seg_q == SEG_DYNAMIC);

  cs_static_slots #(.LEN_W(LEN_W), .SL_W(SL_W)) u_static (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .active     (in_static),
    .slot_len   (cfg_slot_len),
    .slot_count (cfg_static_slots),
    .slot_idx   (slot_num),
    .done       (static_done)
  );

  cs_owner_lookup #(.MAX_SLOTS(MAX_STATIC), .SL_W(SL_W), .NODE_W(NODE_W)) u_owner (
    .owner_table (cfg_owner_table),
    .slot_idx    (slot_num),
    .node_id     (cfg_node_id),
    .match       (owner_hit)
  );

  cs_dynamic #(.MS_W(MS_W), .LEN_W(LEN_W), .NODE_W(NODE_W), .DUR_W(DUR_W)) u_dyn (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .active    (in_dyn),
    .ms_len    (cfg_minislot_len),
    .ms_count  (cfg_minislots),
    .node_id   (cfg_node_id),
    .req_valid (dyn_valid),
    .req_len   (dyn_len),
    .req_ready (dyn_ready),
    .tx_active (dyn_tx),
    .ms_idx    (minislot_num),
    .done      (dyn_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_STATIC;
      tail_cnt <= '0;
      cyc_q    <= '0;
    end else if (tick) begin
      case (seg_q)
        SEG_STATIC: begin
          if (static_done) seg_q <= SEG_DYNAMIC;
        end
        SEG_DYNAMIC: begin
          if (dyn_done) begin
            seg_q    <= SEG_SYMBOL;
            tail_cnt <= '0;
          end
        end
        SEG_SYMBOL: begin
          if (tail_cnt == cfg_symbol_len - LEN_W'(1)) begin
            seg_q    <= SEG_IDLE;
            tail_cnt <= '0;
          end else begin
            tail_cnt <= tail_cnt + LEN_W'(1);
          end
        end
        default: begin
          if (tail_cnt == cfg_idle_len - LEN_W'(1)) begin
            seg_q    <= SEG_STATIC;
            tail_cnt <= '0;
            cyc_q    <= cyc_q + CYC_W'(1);
          end else begin
            tail_cnt <= tail_cnt + LEN_W'(1);
          end
        end
      endcase
    end
  end

  assign seg        = seg_q;
  assign cycle_num  = cyc_q;
  assign own_static = in_static && owner_hit;
endmodule

// File: rtl/cycle_sched_sva.sv
module cycle_sched_sva #(
  parameter int SL_W = 4,
  parameter int MS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [1:0]      seg,
  input logic [SL_W-1:0] slot_num,
  input logic [MS_W-1:0] minislot_num,
  input logic [5:0]      cycle_num,
  input logic            own_static,
  input logic            dyn_tx,
  input logic            dyn_ready,
  input logic            dyn_valid,
  input logic [5:0]      cfg_node_id
);
  assert_seg_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg != $past(seg)) |-> (seg == $past(seg) + 2'd1));

  assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(seg) && $stable(slot_num) && $stable(minislot_num) && $stable(cycle_num)));

  assert_own_in_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
    own_static |-> (seg == 2'd0));

  assert_ready_rules_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_ready |-> (tick && dyn_valid && seg == 2'd1 &&
                   {{(MS_W > 6 ? MS_W - 6 : 0){1'b0}}, cfg_node_id} == minislot_num));

  assert_tx_in_dynamic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_tx |-> (seg == 2'd1));

  assert_minislot_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dyn_tx) && dyn_tx) |-> $stable(minislot_num));

  assert_cycle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_num != $past(cycle_num)) |-> ($past(seg) == 2'd3 && seg == 2'd0 &&
                                         cycle_num == $past(cycle_num) + 6'd1));
endmodule

bind cycle_sched cycle_sched_sva #(.SL_W(SL_W), .MS_W(MS_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .seg          (seg),
  .slot_num     (slot_num),
  .minislot_num (minislot_num),
  .cycle_num    (cycle_num),
  .own_static   (own_static),
  .dyn_tx       (dyn_tx),
  .dyn_ready    (dyn_ready),
  .dyn_valid    (dyn_valid),
  .cfg_node_id  (cfg_node_id)
);

// File: tb/cycle_sched_tb.sv
module cycle_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_STATIC = 8;
  localparam int LEN_W = 8;
  localparam int MS_W  = 8;
  localparam int SL_W  = $clog2(MAX_STATIC + 1);
  localparam int DUR_W = MS_W + LEN_W;

  // Bench configuration: 3 slots x 4, 10 minislots x 2, symbol 3, idle 2
  localparam int M = 3, SLEN = 4, N = 10, MLEN = 2, SYML = 3, IDL = 2;
  localparam int DYN0 = M * SLEN;
  localparam int SYM0 = DYN0 + N * MLEN;
  localparam int IDL0 = SYM0 + SYML;
  localparam int CL   = IDL0 + IDL;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 1;
  logic [5:0] node_id = 6'd2;
  logic [MAX_STATIC*6-1:0] owners;
  logic dyn_valid = 0;
  logic [DUR_W-1:0] dyn_len = '0;
  logic dyn_ready, own_static, dyn_tx;
  logic [1:0] seg;
  logic [SL_W-1:0] slot_num;
  logic [MS_W-1:0] minislot_num;
  logic [5:0] cycle_num;

  int n_chk = 0, n_fail = 0, k = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else if (tick) k <= k + 1;
  end

  cycle_sched #(.MAX_STATIC(MAX_STATIC), .LEN_W(LEN_W), .MS_W(MS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_static_slots(SL_W'(M)), .cfg_slot_len(LEN_W'(SLEN)),
    .cfg_minislots(MS_W'(N)), .cfg_minislot_len(LEN_W'(MLEN)),
    .cfg_symbol_len(LEN_W'(SYML)), .cfg_idle_len(LEN_W'(IDL)),
    .cfg_node_id(node_id), .cfg_owner_table(owners),
    .dyn_valid(dyn_valid), .dyn_len(dyn_len), .dyn_ready(dyn_ready),
    .seg(seg), .slot_num(slot_num), .minislot_num(minislot_num),
    .cycle_num(cycle_num), .own_static(own_static), .dyn_tx(dyn_tx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int e_seg(input int p);
    if (p < DYN0) return 0;
    if (p < SYM0) return 1;
    if (p < IDL0) return 2;
    return 3;
  endfunction

  task automatic do_reset(input logic [5:0] id);
    @(negedge clk);
    rst_n = 0; tick = 1; dyn_valid = 0;
    node_id = id;
    owners = '0;
    owners[5:0] = 6'd5; owners[11:6] = 6'd2; owners[17:12] = 6'd7;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic go_to(input int p);
    while (k % CL != p) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(6'd2);
    chk("R1 seg", seg, 0); chk("R1 slot", slot_num, 0);
    chk("R1 minislot", minislot_num, 0); chk("R1 cycle", cycle_num, 0);
    chk("R1 ready", dyn_ready, 0); chk("R1 tx", dyn_tx, 0);
  endtask

  task automatic t_sweep;
    go_to(0);
    for (int p = 0; p < CL; p++) begin
      chk("R2 seg", seg, e_seg(p));
      chk("R2 slot", slot_num, (p < DYN0) ? p / SLEN : 0);
      chk("R3 minislot", minislot_num, (e_seg(p) == 1) ? (p - DYN0) / MLEN : 0);
      chk("R4 own_static", own_static, (p >= SLEN && p < 2*SLEN) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_gating;
    logic [1:0] s0; logic [SL_W-1:0] sl0; logic [5:0] c0;
    go_to(5);
    tick = 0;
    s0 = seg; sl0 = slot_num; c0 = cycle_num;
    repeat (10) @(negedge clk);
    chk("R6 seg held", seg, s0); chk("R6 slot held", slot_num, sl0);
    chk("R6 cycle held", cycle_num, c0);
    tick = 1;
  endtask

  task automatic t_frame;
    go_to(DYN0 + 2);
    dyn_len = DUR_W'(5); dyn_valid = 1;
    chk("R7 no ready outside own minislot", dyn_ready, 0);
    go_to(DYN0 + 4);
    chk("R7 ready at own minislot", dyn_ready, 1);
    chk("R8 tx first NTU", dyn_tx, 1);
    @(negedge clk); dyn_valid = 0;
    chk("R8 tx second NTU", dyn_tx, 1); chk("R8 minislot held", minislot_num, 2);
    go_to(DYN0 + 8);
    chk("R8 tx last NTU", dyn_tx, 1); chk("R8 minislot still held", minislot_num, 2);
    @(negedge clk);
    chk("R8 tx ended", dyn_tx, 0); chk("R8 next minislot", minislot_num, 3);
    go_to(DYN0 + 11);
    chk("R8 minislot resumes", minislot_num, 4);
  endtask

  task automatic t_too_long;
    go_to(DYN0 + 3);
    dyn_len = DUR_W'(N*MLEN - 4 + 1); dyn_valid = 1;
    go_to(DYN0 + 4);
    chk("R9 oversize no ready", dyn_ready, 0); chk("R9 oversize no tx", dyn_tx, 0);
    go_to(DYN0 + 6);
    chk("R9 minislots keep counting", minislot_num, 3);
    dyn_len = '0;
    go_to(DYN0 + 3);
    go_to(DYN0 + 4);
    chk("R9 zero length no ready", dyn_ready, 0);
    dyn_len = DUR_W'(N*MLEN - 4);
    go_to(DYN0 + 3);
    go_to(DYN0 + 4);
    chk("R9 exact fit ready", dyn_ready, 1);
    @(negedge clk); dyn_valid = 0;
    go_to(SYM0 - 1);
    chk("R9 tx to end", dyn_tx, 1); chk("R9 still dynamic", seg, 1);
    @(negedge clk);
    chk("R9 symbol after fit", seg, 2); chk("R9 tx off", dyn_tx, 0);
    chk("R3 minislot cleared", minislot_num, 0);
  endtask

  task automatic t_wrap;
    int seen;
    do_reset(6'd2);
    while (k != 63*CL) @(negedge clk);
    chk("R5 cycle 63", cycle_num, 63);
    while (k != 64*CL - 1) @(negedge clk);
    chk("R5 last idle", seg, 3); chk("R5 before wrap", cycle_num, 63);
    @(negedge clk);
    chk("R5 wrapped", cycle_num, 0); chk("R5 static again", seg, 0);
    seen = 0;
    while (k != 64*CL + DYN0) @(negedge clk);
    chk("R5 no early step", cycle_num, seen);
  endtask

  task automatic t_unreach;
    int seen = 0;
    do_reset(6'd12);
    dyn_len = DUR_W'(1); dyn_valid = 1;
    for (int i = 0; i < CL; i++) begin
      if (dyn_ready || dyn_tx) seen++;
      @(negedge clk);
    end
    dyn_valid = 0;
    chk("R10 unreachable id never granted", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_gating();
    t_frame();
    t_too_long();
    t_wrap();
    t_unreach();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule